// File: doc/BRIEF.md
# Decimal accumulator stored-program CPU

This block is a small multi-cycle processor built around one accumulator. It holds a unified memory of 100 words for both program and data. Every word carries a decimal value from 0 to 999, kept in binary. An instruction word reads as hundreds digit = operation and the lower two digits = operand address, so the word value equals 100*opcode + address. The processor steps through one register transfer per clock. In the fetch phase the program counter moves to the address register, memory is read into the data register, that value is copied into the instruction register, and the program counter advances. In the execute phase the instruction is decoded, the operand address is loaded, memory is read or written through the data register, the arithmetic result is formed, and finally the accumulator is written.

The block sits in the halted state after reset. Software, or a test harness, loads the program and its data through the preload write port while the block is halted. A one-cycle start pulse then begins execution at address 0. The block runs until it reaches a halting word. The accumulator and the program counter are always visible on debug outputs.

Top module: `dacc_cpu`

## Requirements
- R1: One clock after `rst` is high, `halted` is 1, `acc_out` is 0 and `pc_out` is 0.
- R2: Opcode 5 (word 500+a) loads memory[a] into the accumulator. Running the words 504, 105, 306, 000 with memory[4]=17 and memory[5]=9 leaves the accumulator at 26 and halts with `pc_out`=4.
- R3: Opcode 1 (word 100+a) adds memory[a] to the accumulator, modulo 1000.
- R4: Opcode 2 (word 200+a) subtracts memory[a]. A result below zero wraps modulo 1000 and sets an internal sticky negative flag. Only a load or a start pulse clears that flag. While the flag is set, neither conditional branch is taken.
- R5: Opcode 3 (word 300+a) writes the accumulator to memory[a], and the written value is seen by a later load.
- R6: Opcode 6 (word 600+a) always sets the program counter to a.
- R7: Opcode 7 (word 700+a) branches to a only when the accumulator is 0 and the negative flag is clear. Otherwise execution continues at the next word.
- R8: Opcode 8 (word 800+a) branches to a only when the accumulator is nonzero and the negative flag is clear.
- R9: Opcodes 0, 4 and 9, with any address field, halt the processor. The accumulator is left unchanged and `pc_out` holds the address after the halting word.
- R10: The program counter increments from 99 to 0.
- R11: Preload writes take effect only while halted. A write attempted while running changes no memory word.
- R12: Counted from the first cycle with `halted` low, instructions take these numbers of cycles: load, add and subtract 9, store 7, branch and halt 5. A start pulse while halted drops `halted` on the next cycle, with `pc_out` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pre_we | input | 1 | Preload write strobe, honoured only while halted |
| pre_addr | input | 7 | Preload word address, 0 to 99 |
| pre_data | input | 10 | Preload word value, 0 to 999 |
| start | input | 1 | Begin execution at address 0 when halted |
| halted | output | 1 | High while in the halted idle state |
| acc_out | output | 10 | Accumulator value |
| pc_out | output | 7 | Program counter value |

## Verification
Internal state appears at the ports in two ways: through the accumulator, program counter and halted flag at the end of a program, and through the number of cycles `halted` stays low. A wrong register transfer, such as a data register captured one cycle early or a program counter that fails to advance or to wrap, changes the final accumulator or `pc_out` when the halting word is reached. A wrong step count shows as an altered run length. The hidden negative flag and the memory contents are brought out by follow-up instructions: conditional branches whose targets hold halting words at distinct addresses, and a load of the stored word. Each fault therefore shows within one short program run.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_F_MAR,
      ST_F_READ,
      ST_F_MDR,
      ST_F_IR,
      ST_E_DEC,
      ST_E_READ,
      ST_E_MDR,
      ST_E_ALU,
      ST_E_ACC,
      ST_E_STAGE,
      ST_E_WRITE
   } state_t;

   typedef enum logic [2:0] {
      OP_HALT,
      OP_ADD,
      OP_SUB,
      OP_STA,
      OP_LDA,
      OP_BR,
      OP_BRZ,
      OP_BRP
   } op_t;

endpackage

// File: rtl/dacc_mem.sv
module dacc_mem #(
   parameter int WORD_W = 10,
   parameter int ADDR_W = 7,
   parameter int DEPTH  = 100
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [WORD_W-1:0] rdata
);

   logic [WORD_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         store[waddr] <= wdata;
      end
      rdata <= store[raddr];
   end

endmodule

// File: rtl/dacc_decode.sv
module dacc_decode
   import dacc_pkg::*;
#(
   parameter int WORD_W = 10,
   parameter int ADDR_W = 7,
   parameter int RADIX  = 100
) (
   input  logic [WORD_W-1:0] word,
   output op_t               op,
   output logic [ADDR_W-1:0] field
);

   logic [WORD_W-1:0] digit;
   logic [WORD_W-1:0] rest;

   always_comb begin
      digit = word / WORD_W'(RADIX);
      rest  = word % WORD_W'(RADIX);
      field = rest[ADDR_W-1:0];
      case (digit)
         WORD_W'(1): op = OP_ADD;
         WORD_W'(2): op = OP_SUB;
         WORD_W'(3): op = OP_STA;
         WORD_W'(5): op = OP_LDA;
         WORD_W'(6): op = OP_BR;
         WORD_W'(7): op = OP_BRZ;
         WORD_W'(8): op = OP_BRP;
         default:    op = OP_HALT;
      endcase
   end

endmodule

// File: rtl/dacc_alu.sv
module dacc_alu #(
   parameter int WORD_W   = 10,
   parameter int WORD_MOD = 1000
) (
   input  logic              is_sub,
   input  logic [WORD_W-1:0] a,
   input  logic [WORD_W-1:0] b,
   output logic [WORD_W-1:0] res,
   output logic              under
);

   localparam logic [WORD_W:0] MODV = (WORD_W+1)'(WORD_MOD);

   logic [WORD_W:0] ax;
   logic [WORD_W:0] bx;
   logic [WORD_W:0] tmp;

   always_comb begin
      ax    = {1'b0, a};
      bx    = {1'b0, b};
      under = 1'b0;
      if (is_sub) begin
         under = (ax < bx);
         tmp   = under ? (ax + MODV - bx) : (ax - bx);
      end else begin
         tmp = ax + bx;
         if (tmp >= MODV) begin
            tmp = tmp - MODV;
         end
      end
      res = tmp[WORD_W-1:0];
   end

endmodule

// File: rtl/dacc_cpu.sv
module dacc_cpu
   import dacc_pkg::*;
#(
   parameter  int MEM_DEPTH = 100,
   localparam int ADDR_W    = $clog2(MEM_DEPTH),
   localparam int WORD_MOD  = 10 * MEM_DEPTH,
   localparam int WORD_W    = $clog2(WORD_MOD)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pre_we,
   input  logic [ADDR_W-1:0] pre_addr,
   input  logic [WORD_W-1:0] pre_data,
   input  logic              start,
   output logic              halted,
   output logic [WORD_W-1:0] acc_out,
   output logic [ADDR_W-1:0] pc_out
);

   generate
      if (MEM_DEPTH < 2) begin : g_bad_depth
         $error("dacc_cpu: MEM_DEPTH must be at least 2");
      end
      if (WORD_MOD > (1 << WORD_W)) begin : g_bad_word
         $error("dacc_cpu: word width too small for the decimal range");
      end
   endgenerate

   state_t            state;
   logic [ADDR_W-1:0] pc;
   logic [ADDR_W-1:0] mar;
   logic [WORD_W-1:0] mdr;
   logic [WORD_W-1:0] ir;
   logic [WORD_W-1:0] acc;
   logic [WORD_W-1:0] res_q;
   logic              under_q;
   logic              neg_q;

   logic [ADDR_W-1:0] pc_next;
   op_t               op;
   logic [ADDR_W-1:0] field;
   logic [WORD_W-1:0] alu_res;
   logic              alu_under;

   logic              mem_we;
   logic [ADDR_W-1:0] mem_waddr;
   logic [WORD_W-1:0] mem_wdata;
   logic [WORD_W-1:0] mem_rdata;
   logic              pre_ok;

   // program counter increment: free wrap for power-of-two depth, compare otherwise
   generate
      if ((1 << ADDR_W) == MEM_DEPTH) begin : g_pc_pow2
         assign pc_next = pc + 1'b1;
      end else begin : g_pc_cmp
         assign pc_next = (pc == ADDR_W'(MEM_DEPTH - 1)) ? '0 : pc + 1'b1;
      end
   endgenerate

   dacc_decode #(
      .WORD_W(WORD_W),
      .ADDR_W(ADDR_W),
      .RADIX (MEM_DEPTH)
   ) u_decode (
      .word (ir),
      .op   (op),
      .field(field)
   );

   dacc_alu #(
      .WORD_W  (WORD_W),
      .WORD_MOD(WORD_MOD)
   ) u_alu (
      .is_sub(op == OP_SUB),
      .a     (acc),
      .b     (mdr),
      .res   (alu_res),
      .under (alu_under)
   );

   assign pre_ok    = pre_we && (pre_addr < ADDR_W'(MEM_DEPTH));
   assign mem_we    = (state == ST_IDLE) ? pre_ok : (state == ST_E_WRITE);
   assign mem_waddr = (state == ST_IDLE) ? pre_addr : mar;
   assign mem_wdata = (state == ST_IDLE) ? pre_data : mdr;

   dacc_mem #(
      .WORD_W(WORD_W),
      .ADDR_W(ADDR_W),
      .DEPTH (MEM_DEPTH)
   ) u_mem (
      .clk  (clk),
      .we   (mem_we),
      .waddr(mem_waddr),
      .wdata(mem_wdata),
      .raddr(mar),
      .rdata(mem_rdata)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_IDLE;
         pc      <= '0;
         mar     <= '0;
         mdr     <= '0;
         ir      <= '0;
         acc     <= '0;
         res_q   <= '0;
         under_q <= 1'b0;
         neg_q   <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  pc    <= '0;
                  neg_q <= 1'b0;
                  state <= ST_F_MAR;
               end
            end
            ST_F_MAR: begin
               mar   <= pc;
               state <= ST_F_READ;
            end
            ST_F_READ: begin
               state <= ST_F_MDR;
            end
            ST_F_MDR: begin
               mdr   <= mem_rdata;
               state <= ST_F_IR;
            end
            ST_F_IR: begin
               ir    <= mdr;
               pc    <= pc_next;
               state <= ST_E_DEC;
            end
            ST_E_DEC: begin
               case (op)
                  OP_HALT: state <= ST_IDLE;
                  OP_BR: begin
                     pc    <= field;
                     state <= ST_F_MAR;
                  end
                  OP_BRZ: begin
                     if (acc == '0 && !neg_q) begin
                        pc <= field;
                     end
                     state <= ST_F_MAR;
                  end
                  OP_BRP: begin
                     if (acc != '0 && !neg_q) begin
                        pc <= field;
                     end
                     state <= ST_F_MAR;
                  end
                  OP_STA: begin
                     mar   <= field;
                     state <= ST_E_STAGE;
                  end
                  default: begin
                     mar   <= field;
                     state <= ST_E_READ;
                  end
               endcase
            end
            ST_E_STAGE: begin
               mdr   <= acc;
               state <= ST_E_WRITE;
            end
            ST_E_WRITE: begin
               state <= ST_F_MAR;
            end
            ST_E_READ: begin
               state <= ST_E_MDR;
            end
            ST_E_MDR: begin
               mdr   <= mem_rdata;
               state <= ST_E_ALU;
            end
            ST_E_ALU: begin
               res_q   <= (op == OP_LDA) ? mdr : alu_res;
               under_q <= (op == OP_SUB) && alu_under;
               state   <= ST_E_ACC;
            end
            ST_E_ACC: begin
               acc <= res_q;
               if (op == OP_LDA) begin
                  neg_q <= 1'b0;
               end else if (under_q) begin
                  neg_q <= 1'b1;
               end
               state <= ST_F_MAR;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign halted  = (state == ST_IDLE);
   assign acc_out = acc;
   assign pc_out  = pc;

endmodule

// File: rtl/dacc_cpu_chk.sv
module dacc_cpu_chk #(
   parameter  int MEM_DEPTH = 100,
   localparam int ADDR_W    = $clog2(MEM_DEPTH),
   localparam int WORD_MOD  = 10 * MEM_DEPTH,
   localparam int WORD_W    = $clog2(WORD_MOD)
) (
   input logic              clk,
   input logic              rst,
   input logic              start,
   input logic              halted,
   input logic [WORD_W-1:0] acc_out,
   input logic [ADDR_W-1:0] pc_out
);

   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (halted && acc_out == '0 && pc_out == '0));

   assert_pc_range_R10: assert property (@(posedge clk) disable iff (rst)
      pc_out < ADDR_W'(MEM_DEPTH));

   assert_acc_range_R3: assert property (@(posedge clk) disable iff (rst)
      acc_out < WORD_W'(WORD_MOD));

   assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
      (halted && !start) |=> (halted && $stable(acc_out) && $stable(pc_out)));

   assert_start_leaves_idle_R12: assert property (@(posedge clk) disable iff (rst)
      (halted && start) |=> (!halted && pc_out == '0));

endmodule

bind dacc_cpu dacc_cpu_chk #(.MEM_DEPTH(MEM_DEPTH)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .start  (start),
   .halted (halted),
   .acc_out(acc_out),
   .pc_out (pc_out)
);

// File: tb/tb_dacc_cpu.sv
module tb_dacc_cpu;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       pre_we = 1'b0;
   logic [6:0] pre_addr = '0;
   logic [9:0] pre_data = '0;
   logic       start = 1'b0;
   logic       halted;
   logic [9:0] acc_out;
   logic [6:0] pc_out;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   dacc_cpu dut (
      .clk     (clk),
      .rst     (rst),
      .pre_we  (pre_we),
      .pre_addr(pre_addr),
      .pre_data(pre_data),
      .start   (start),
      .halted  (halted),
      .acc_out (acc_out),
      .pc_out  (pc_out)
   );

   always #5 clk = ~clk;

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic poke(input int a, input int v);
      @(negedge clk);
      pre_we   = 1'b1;
      pre_addr = 7'(a);
      pre_data = 10'(v);
      @(negedge clk);
      pre_we   = 1'b0;
   endtask

   task automatic run(input bit inj, input int ia, input int iv, output int cyc);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (!halted && cyc < 2000) begin
         cyc++;
         if (inj && cyc == 2) begin
            pre_we   = 1'b1;
            pre_addr = 7'(ia);
            pre_data = 10'(iv);
         end else begin
            pre_we = 1'b0;
         end
         @(negedge clk);
      end
      pre_we = 1'b0;
   endtask

   task automatic t_reset();
      int c;
      do_reset();
      chk("R1 halted", int'(halted), 1);
      chk("R1 acc", int'(acc_out), 0);
      chk("R1 pc", int'(pc_out), 0);
      c = 0;
      c = c;
   endtask

   task automatic t_sum();
      int c;
      do_reset();
      poke(0, 504); poke(1, 105); poke(2, 306); poke(3, 0);
      poke(4, 17);  poke(5, 9);   poke(6, 0);
      run(1'b1, 5, 500, c);
      chk("R2 acc", int'(acc_out), 26);
      chk("R2 pc", int'(pc_out), 4);
      chk("R2 halted", int'(halted), 1);
      chk("R11 running write ignored", int'(acc_out), 26);
      chk("R12 cycles", c, 30);
      poke(0, 506); poke(1, 0);
      run(1'b0, 0, 0, c);
      chk("R5 stored word", int'(acc_out), 26);
      chk("R12 cycles load+halt", c, 14);
      // preload while halted does take effect
      poke(5, 40); poke(0, 505);
      run(1'b0, 0, 0, c);
      chk("R11 halted write", int'(acc_out), 40);
   endtask

   task automatic t_add_wrap();
      int c;
      do_reset();
      poke(0, 510); poke(1, 111); poke(2, 0);
      poke(10, 600); poke(11, 500);
      run(1'b0, 0, 0, c);
      chk("R3 add wrap", int'(acc_out), 100);
      chk("R3 pc", int'(pc_out), 3);
   endtask

   task automatic t_sub_neg();
      int c;
      do_reset();
      poke(10, 3); poke(11, 5); poke(12, 4);
      poke(20, 0); poke(21, 0);
      poke(0, 510); poke(1, 211); poke(2, 720); poke(3, 821); poke(4, 0);
      run(1'b0, 0, 0, c);
      chk("R4 sub wrap", int'(acc_out), 998);
      chk("R4 no branch while negative", int'(pc_out), 5);
      // start clears the flag: BRP taken on 998
      poke(0, 821);
      run(1'b0, 0, 0, c);
      chk("R4 start clears flag", int'(pc_out), 22);
      chk("R8 branch cycles", c, 10);
      // load clears the flag
      poke(0, 510); poke(1, 211); poke(2, 512); poke(3, 821); poke(4, 0);
      run(1'b0, 0, 0, c);
      chk("R4 load clears flag", int'(pc_out), 22);
      chk("R4 acc after load", int'(acc_out), 4);
      // exact zero difference: BRZ taken
      poke(0, 510); poke(1, 210); poke(2, 720); poke(3, 0);
      run(1'b0, 0, 0, c);
      chk("R7 zero taken", int'(pc_out), 21);
      chk("R4 zero acc", int'(acc_out), 0);
   endtask

   task automatic t_cond();
      int c;
      do_reset();
      poke(10, 3); poke(13, 0); poke(20, 0); poke(21, 0);
      poke(0, 513); poke(1, 821); poke(2, 0);
      run(1'b0, 0, 0, c);
      chk("R8 zero not taken", int'(pc_out), 3);
      poke(0, 510); poke(1, 720); poke(2, 0);
      run(1'b0, 0, 0, c);
      chk("R7 nonzero not taken", int'(pc_out), 3);
      poke(1, 821);
      run(1'b0, 0, 0, c);
      chk("R8 positive taken", int'(pc_out), 22);
   endtask

   task automatic t_br();
      int c;
      do_reset();
      poke(0, 630); poke(30, 0);
      run(1'b0, 0, 0, c);
      chk("R6 branch", int'(pc_out), 31);
      chk("R6 cycles", c, 10);
   endtask

   task automatic t_halts();
      int c;
      do_reset();
      poke(10, 3); poke(0, 510);
      poke(1, 455);
      run(1'b0, 0, 0, c);
      chk("R9 opcode 4 pc", int'(pc_out), 2);
      chk("R9 opcode 4 acc", int'(acc_out), 3);
      chk("R12 halt cycles", c, 14);
      poke(1, 912);
      run(1'b0, 0, 0, c);
      chk("R9 opcode 9 pc", int'(pc_out), 2);
      poke(1, 42);
      run(1'b0, 0, 0, c);
      chk("R9 zero opcode nonzero field", int'(pc_out), 2);
      chk("R9 acc kept", int'(acc_out), 3);
   endtask

   task automatic t_wrap();
      int c;
      do_reset();
      poke(0, 799); poke(99, 510); poke(10, 5); poke(1, 0);
      run(1'b0, 0, 0, c);
      chk("R10 wrap pc", int'(pc_out), 2);
      chk("R10 wrap acc", int'(acc_out), 5);
   endtask

   task automatic t_store_sta();
      int c;
      do_reset();
      poke(10, 123); poke(40, 0);
      poke(0, 510); poke(1, 340); poke(2, 0);
      run(1'b0, 0, 0, c);
      chk("R12 store cycles", c, 21);
      poke(0, 540); poke(1, 0);
      run(1'b0, 0, 0, c);
      chk("R5 store then load", int'(acc_out), 123);
   endtask

   initial begin
      t_reset();
      t_sum();
      t_add_wrap();
      t_sub_neg();
      t_cond();
      t_br();
      t_halts();
      t_wrap();
      t_store_sta();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule